// File: doc/BRIEF.md
# Guard-Prefixed Symbol Serializer

This block sits after an 8-point inverse transform. It takes one complete symbol in parallel: eight complex samples, each with a 16-bit real part and a 16-bit imaginary part. It builds a frame by placing a guard prefix in front of the symbol, and the prefix is a copy of the symbol's tail. A counter-driven shifter then sends the frame downstream as 16-bit words, one word per clock.

The symbol has sixteen words and the prefix has three, so the parallel frame is 304 bits wide and takes nineteen cycles to send. Upstream logic presents a symbol together with a load strobe. The strobe is accepted on a clock edge where the busy output is low. While a frame is draining, the busy output is high and any further load strobe is dropped. Busy falls in the cycle after the last word, and a new load can be accepted at the edge that ends that cycle.

Top module: `cps_serializer`

## Requirements
- R1: A high level on the asynchronous reset `rst_i` drives `word_vld_o`, `busy_o` and `word_o` to zero at once, with no clock edge needed, and they stay at zero while reset is held.
- R2: A rising clock edge that sees `load_i` high and `busy_o` low accepts a frame, and `word_vld_o` is high in the cycle that follows that edge.
- R3: For each accepted frame, `word_vld_o` is high for exactly 19 consecutive cycles and then goes low.
- R4: The first three valid words are symbol words 13, 14 and 15 of the serial order defined in R5, in that order: imaginary part of sample 6, real part of sample 7, imaginary part of sample 7.
- R5: Valid words 4 to 19 are the symbol in serial order: sample 0 to sample 7, with the real word before the imaginary word in each sample. The real part of sample k is `sym_re_i[16k+15:16k]` and the imaginary part is `sym_im_i[16k+15:16k]`.
- R6: A `load_i` pulse that arrives while `busy_o` is high is ignored. The frame in flight keeps its word sequence and its length of 19 words.
- R7: The symbol inputs are sampled only at the edge that accepts a frame. Any change on them during the drain has no effect on the words sent.
- R8: `busy_o` is high in every cycle in which `word_vld_o` is high and low otherwise, so a new frame can be loaded at the edge that ends the first cycle after the last word.
- R9: `word_o` is zero in every cycle in which `word_vld_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Asynchronous reset, active high |
| sym_re_i | input | 128 | Real parts of the eight samples, sample k in bits 16k+15:16k |
| sym_im_i | input | 128 | Imaginary parts of the eight samples, sample k in bits 16k+15:16k |
| load_i | input | 1 | Load strobe, accepted only while not busy |
| word_o | output | 16 | Serial output word |
| word_vld_o | output | 1 | High while word_o carries a frame word |
| busy_o | output | 1 | High while a frame is draining |

## Verification
The bench targets the prefix order, because a design that copies the wrong tail words or reverses them puts a wrong value in one of the first three slots. It pulses load at random and changes the symbol inputs during drains. A design that restarts on a load during a drain sends a longer burst, and a design that reads the inputs live sends words from the new data. Back-to-back frames test the turnaround: an off-by-one in the counter shows up as 18 or 20 valid words, or as a load that is lost at the first idle cycle. A reset in the middle of a frame must clear the outputs at once, without waiting for a clock edge.

// File: rtl/cps_pkg.sv
package cps_pkg;

    // Map a frame word position to the symbol word it carries.
    // Positions below cp_words hold the tail of the symbol; the rest
    // hold the symbol from its first word onwards.
    function automatic int frame_to_sym(input int pos, input int cp_words,
                                        input int sym_words);
        if (pos < cp_words) begin
            return sym_words - cp_words + pos;
        end
        return pos - cp_words;
    endfunction

endpackage

// File: rtl/cps_frame_build.sv
module cps_frame_build #(
    parameter int SAMPLES  = 8,
    parameter int WORD_W   = 16,
    parameter int CP_WORDS = 3,
    localparam int SYM_WORDS   = 2 * SAMPLES,
    localparam int FRAME_WORDS = SYM_WORDS + CP_WORDS,
    localparam int PLANE_W     = SAMPLES * WORD_W,
    localparam int FRAME_W     = FRAME_WORDS * WORD_W
) (
    input  logic [PLANE_W-1:0] re_i,
    input  logic [PLANE_W-1:0] im_i,
    output logic [FRAME_W-1:0] frame_o
);

    // Frame word 0 sits in the low bits and leaves first.
    for (genvar pos = 0; pos < FRAME_WORDS; pos++) begin : g_word
        localparam int SRC = cps_pkg::frame_to_sym(pos, CP_WORDS, SYM_WORDS);
        localparam int SMP = SRC / 2;
        if ((SRC % 2) == 0) begin : g_re
            assign frame_o[pos*WORD_W +: WORD_W] = re_i[SMP*WORD_W +: WORD_W];
        end else begin : g_im
            assign frame_o[pos*WORD_W +: WORD_W] = im_i[SMP*WORD_W +: WORD_W];
        end
    end

endmodule

// File: rtl/cps_shifter.sv
module cps_shifter #(
    parameter int WORD_W      = 16,
    parameter int FRAME_WORDS = 19,
    localparam int FRAME_W = FRAME_WORDS * WORD_W,
    localparam int CNT_W   = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               load_i,
    input  logic [FRAME_W-1:0] frame_i,
    output logic [WORD_W-1:0]  word_o,
    output logic               active_o
);

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic [CNT_W-1:0]   left;
        logic               active;
    } shift_state_t;

    shift_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.active) begin
            if (load_i) begin
                st_d.frame  = frame_i;
                st_d.left   = CNT_W'(FRAME_WORDS - 1);
                st_d.active = 1'b1;
            end
        end else begin
            st_d.frame = st_q.frame >> WORD_W;
            if (st_q.left == '0) begin
                st_d.active = 1'b0;
            end else begin
                st_d.left = st_q.left - 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o   = st_q.active ? st_q.frame[WORD_W-1:0] : '0;
    assign active_o = st_q.active;

endmodule

// File: rtl/cps_serializer.sv
module cps_serializer #(
    parameter int SAMPLES  = 8,
    parameter int WORD_W   = 16,
    parameter int CP_WORDS = 3,
    localparam int SYM_WORDS   = 2 * SAMPLES,
    localparam int FRAME_WORDS = SYM_WORDS + CP_WORDS,
    localparam int PLANE_W     = SAMPLES * WORD_W,
    localparam int FRAME_W     = FRAME_WORDS * WORD_W
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [PLANE_W-1:0] sym_re_i,
    input  logic [PLANE_W-1:0] sym_im_i,
    input  logic               load_i,
    output logic [WORD_W-1:0]  word_o,
    output logic               word_vld_o,
    output logic               busy_o
);

    logic [FRAME_W-1:0] frame;
    logic               active;

    cps_frame_build #(
        .SAMPLES (SAMPLES),
        .WORD_W  (WORD_W),
        .CP_WORDS(CP_WORDS)
    ) build_i (
        .re_i   (sym_re_i),
        .im_i   (sym_im_i),
        .frame_o(frame)
    );

    cps_shifter #(
        .WORD_W     (WORD_W),
        .FRAME_WORDS(FRAME_WORDS)
    ) shift_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .load_i  (load_i),
        .frame_i (frame),
        .word_o  (word_o),
        .active_o(active)
    );

    assign word_vld_o = active;
    assign busy_o     = active;

endmodule

// File: rtl/cps_checker.sv
module cps_checker #(
    parameter int SAMPLES  = 8,
    parameter int WORD_W   = 16,
    parameter int CP_WORDS = 3,
    localparam int SYM_WORDS   = 2 * SAMPLES,
    localparam int FRAME_WORDS = SYM_WORDS + CP_WORDS,
    localparam int PLANE_W     = SAMPLES * WORD_W,
    localparam int RUN_W       = $clog2(FRAME_WORDS + 1)
) (
    input logic               clk_i,
    input logic               rst_i,
    input logic [PLANE_W-1:0] sym_re_i,
    input logic [PLANE_W-1:0] sym_im_i,
    input logic               load_i,
    input logic [WORD_W-1:0]  word_o,
    input logic               word_vld_o,
    input logic               busy_o
);

    function automatic logic [WORD_W-1:0] pick(input logic [PLANE_W-1:0] re,
                                               input logic [PLANE_W-1:0] im,
                                               input int idx);
        int s;
        s = idx / 2;
        if ((idx % 2) == 1) begin
            return im[s*WORD_W +: WORD_W];
        end
        return re[s*WORD_W +: WORD_W];
    endfunction

    // Valid cycles already seen in the current burst.
    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            run_q <= '0;
        end else if (word_vld_o) begin
            run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    assert_load_starts_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (load_i && !busy_o) |=> word_vld_o);

    assert_burst_ends_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (word_vld_o && run_q == RUN_W'(FRAME_WORDS - 1)) |=> !word_vld_o);

    assert_burst_full_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(word_vld_o) |-> ($past(run_q) == RUN_W'(FRAME_WORDS - 1)));

    assert_no_restart_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (word_vld_o && load_i && run_q != RUN_W'(FRAME_WORDS - 1)) |=> word_vld_o);

    assert_prefix_head_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(word_vld_o) |->
            (word_o == pick($past(sym_re_i), $past(sym_im_i), SYM_WORDS - CP_WORDS)));

    assert_idle_zero_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        !word_vld_o |-> (word_o == '0));

endmodule

bind cps_serializer cps_checker #(
    .SAMPLES (SAMPLES),
    .WORD_W  (WORD_W),
    .CP_WORDS(CP_WORDS)
) chk_i (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .sym_re_i  (sym_re_i),
    .sym_im_i  (sym_im_i),
    .load_i    (load_i),
    .word_o    (word_o),
    .word_vld_o(word_vld_o),
    .busy_o    (busy_o)
);

// File: tb/cps_serializer_tb.sv
module cps_serializer_tb_top;

    localparam int NS = 8;
    localparam int W  = 16;
    localparam int CP = 3;
    localparam int SYMW = 2 * NS;
    localparam int FW   = SYMW + CP;
    localparam int PW   = NS * W;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [PW-1:0] sym_re = '0;
    logic [PW-1:0] sym_im = '0;
    logic          load = 1'b0;
    logic [W-1:0]  word;
    logic          vld;
    logic          busy;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #5 clk = ~clk;

    cps_serializer #(.SAMPLES(NS), .WORD_W(W), .CP_WORDS(CP)) dut_i (
        .clk_i     (clk),
        .rst_i     (rst),
        .sym_re_i  (sym_re),
        .sym_im_i  (sym_im),
        .load_i    (load),
        .word_o    (word),
        .word_vld_o(vld),
        .busy_o    (busy)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] exp_word(input logic [PW-1:0] re,
                                              input logic [PW-1:0] im,
                                              input int pos);
        int idx;
        int s;
        idx = (pos < CP) ? (SYMW - CP + pos) : (pos - CP);
        s = idx / 2;
        return (idx % 2 == 1) ? im[s*W +: W] : re[s*W +: W];
    endfunction

    function automatic logic [PW-1:0] rnd_plane();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    // Load a frame at a negedge and follow it word by word.
    task automatic send_frame(input logic [PW-1:0] re, input logic [PW-1:0] im,
                              input bit noise);
        @(negedge clk);
        sym_re = re;
        sym_im = im;
        load   = 1'b1;
        for (int j = 0; j < FW; j++) begin
            @(negedge clk);
            chk(vld == 1'b1, "R3 valid in burst", 32'(vld), 32'd1);
            chk(busy == 1'b1, "R8 busy in burst", 32'(busy), 32'd1);
            if (j < CP) begin
                chk(word == exp_word(re, im, j), "R4 prefix word", 32'(word),
                    32'(exp_word(re, im, j)));
            end else if (noise) begin
                chk(word == exp_word(re, im, j), "R6 R7 word under noise", 32'(word),
                    32'(exp_word(re, im, j)));
            end else begin
                chk(word == exp_word(re, im, j), "R5 symbol word", 32'(word),
                    32'(exp_word(re, im, j)));
            end
            if (noise) begin
                load   = 1'($urandom % 2);
                sym_re = rnd_plane();
                sym_im = rnd_plane();
            end else begin
                load = 1'b0;
            end
        end
        @(negedge clk);
        chk(vld == 1'b0, "R3 valid ends after 19", 32'(vld), 32'd0);
        chk(busy == 1'b0, "R8 busy ends", 32'(busy), 32'd0);
        chk(word == '0, "R9 idle word zero", 32'(word), 32'd0);
        load = 1'b0;
    endtask

    initial begin
        logic [PW-1:0] re;
        logic [PW-1:0] im;
        void'($urandom(32'h5eed_1234));
        repeat (2) @(negedge clk);
        chk(vld == 1'b0 && busy == 1'b0 && word == '0, "R1 reset state",
            {word, 14'd0, vld, busy}, 32'd0);
        rst = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk(vld == 1'b0 && word == '0, "R9 idle without load", {word, 15'd0, vld}, 32'd0);
        end

        // Directed: tagged words to expose ordering.
        for (int k = 0; k < NS; k++) begin
            re[k*W +: W] = 16'hA000 + 16'(k);
            im[k*W +: W] = 16'hB000 + 16'(k);
        end
        send_frame(re, im, 1'b0);
        send_frame('0, '1, 1'b0);
        send_frame('1, '0, 1'b0);

        // Back-to-back loads: held high across the turnaround (R2).
        @(negedge clk);
        re = rnd_plane();
        im = rnd_plane();
        sym_re = re;
        sym_im = im;
        load = 1'b1;
        @(negedge clk);
        chk(vld == 1'b1, "R2 load accepted", 32'(vld), 32'd1);
        for (int j = 1; j < FW; j++) @(negedge clk);
        chk(vld == 1'b1 && word == exp_word(re, im, FW - 1), "R3 last word",
            32'(word), 32'(exp_word(re, im, FW - 1)));
        @(negedge clk);
        chk(vld == 1'b0, "R8 idle gap cycle", 32'(vld), 32'd0);
        re = rnd_plane();
        sym_re = re;
        @(negedge clk);
        chk(vld == 1'b1 && word == exp_word(re, im, 0), "R2 reload after gap",
            32'(word), 32'(exp_word(re, im, 0)));
        load = 1'b0;
        for (int j = 1; j < FW; j++) @(negedge clk);
        @(negedge clk);
        chk(vld == 1'b0, "R3 reload burst length", 32'(vld), 32'd0);

        // Random frames with loads and input changes during drains.
        for (int f = 0; f < 40; f++) begin
            send_frame(rnd_plane(), rnd_plane(), 1'b1);
        end

        // Reset in the middle of a frame.
        @(negedge clk);
        sym_re = rnd_plane();
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        repeat (5) @(negedge clk);
        #1 rst = 1'b1;
        #1;
        chk(vld == 1'b0 && busy == 1'b0 && word == '0, "R1 async reset mid frame",
            {word, 14'd0, vld, busy}, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk(vld == 1'b0, "R1 stays idle after reset", 32'(vld), 32'd0);
        end
        send_frame(rnd_plane(), rnd_plane(), 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule